// File: doc/BRIEF.md
# Trap Entry Mode Selector and Handler Vector Generator

This block sits at the front of a processor's trap entry path. It takes the current trap nesting depth, the three machine state bits that describe privilege and recovery state, the privilege level the trap is aimed at, the raw trap type, and the two handler table base registers. From these it picks one of five entry modes and produces the handler's program counter along with the two fetch addresses that follow it.

Selection is a strict priority chain. The recovery (RED) entry comes first. The error stop comes next, then the guest-watchdog redirect into the hypervisor, then a normal hypervisor entry, and last an ordinary privileged entry. Each normal mode indexes its own table. The hypervisor table is aligned to 16 KiB. The privileged table is aligned to 32 KiB and has an upper half that is used for nested traps. The recovery vector is a fixed address. The saving of architectural state and the fetch from the handler are done elsewhere.

The decode is combinational. A parameter adds one output register stage. With the default setting, results appear one clock after the inputs and the outputs clear to zero under reset.

Top module: `trap_vector_gen`

## Requirements
- R1: `cur_lvl_o` reports the present privilege level: 2 when the hypervisor bit is set, otherwise 1 when the privileged bit is set, otherwise 0.
- R2: When the recovery bit is set, or the trap level equals MAX_TL-1, the mode is RED (`mode_o` bit 0). This takes priority over every other mode. The effective type is 5 and the PC is 0xFFF0000000 ORed with ((5<<5) & 0xFF), which is 0xFFF00000A0.
- R3: Outside RED, a trap level of MAX_TL or above selects the error mode (`mode_o` bit 1). PC, NPC and NNPC are then all zero and the effective type equals the input type.
- R4: Outside RED and error, a trap level above MAX_PTL with a target level of 1 selects guest-watchdog (`mode_o` bit 2). The effective type is 2, and the PC is the hypervisor base with bits 13:0 cleared, ORed with 0x040.
- R5: Otherwise, a target level of 2 selects hypervisor entry (`mode_o` bit 3). The PC is the hypervisor base with bits 13:0 cleared, ORed with ((type<<5) & 0x3FFF).
- R6: In all remaining cases the mode is privileged entry (`mode_o` bit 4). The PC is the privileged base with bits 14:0 cleared, ORed with bit 14 when the trap level is 1 or more (so the new level is above 1), and ORed with ((type<<5) & 0x3FFF).
- R7: In every mode except error, NPC = PC+4 and NNPC = NPC+4.
- R8: Exactly one bit of `mode_o` is set whenever the block is out of reset.
- R9: With REG_OUT=1, each output reflects the inputs of the previous clock edge. While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low synchronous reset |
| tl_i | input | TLW | Current trap level |
| pstate_priv_i | input | 1 | Privileged bit of the processor state |
| hpstate_hpriv_i | input | 1 | Hypervisor bit of the hypervisor state |
| hpstate_red_i | input | 1 | Recovery bit of the hypervisor state |
| tgt_lvl_i | input | 2 | Target privilege level (0 user, 1 privileged, 2 hypervisor) |
| tt_i | input | TTW | Raw trap type |
| tba_i | input | AW | Privileged handler table base |
| htba_i | input | AW | Hypervisor handler table base |
| cur_lvl_o | output | 2 | Present privilege level |
| mode_o | output | 5 | One-hot entry mode: bit0 RED, bit1 error, bit2 guest-watchdog, bit3 hypervisor, bit4 privileged |
| eff_tt_o | output | TTW | Trap type to record |
| pc_o | output | AW | Handler PC |
| npc_o | output | AW | Handler next PC |
| nnpc_o | output | AW | Handler next-next PC |

## Verification
The assertions look only at the outputs. They assume every input is stable for a whole cycle, so that a registered result always comes from one consistent set of inputs. They also assume MAX_TL fits in the trap level field. The bench drives inputs only on falling edges. It draws trap levels across the full field, including values at and above MAX_TL, and target levels across all four codes. Every output therefore comes from a legal, settled input set, while each priority boundary is still crossed.

// File: rtl/trap_vector_gen.sv
module trap_vector_gen #(
  parameter int AW      = 64,
  parameter int TLW     = 3,
  parameter int TTW     = 9,
  parameter int MAX_TL  = 6,
  parameter int MAX_PTL = 2,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TLW-1:0] tl_i,
  input  logic           pstate_priv_i,
  input  logic           hpstate_hpriv_i,
  input  logic           hpstate_red_i,
  input  logic [1:0]     tgt_lvl_i,
  input  logic [TTW-1:0] tt_i,
  input  logic [AW-1:0]  tba_i,
  input  logic [AW-1:0]  htba_i,
  output logic [1:0]     cur_lvl_o,
  output logic [4:0]     mode_o,
  output logic [TTW-1:0] eff_tt_o,
  output logic [AW-1:0]  pc_o,
  output logic [AW-1:0]  npc_o,
  output logic [AW-1:0]  nnpc_o
);
  localparam logic [TLW-1:0] TL_RED   = TLW'(MAX_TL - 1);
  localparam logic [TLW-1:0] TL_ERR   = TLW'(MAX_TL);
  localparam logic [TLW-1:0] TL_PMAX  = TLW'(MAX_PTL);
  localparam logic [AW-1:0]  RED_BASE = AW'(40'hFF_F000_0000);
  localparam logic [TTW-1:0] TT_RED   = TTW'(5);
  localparam logic [TTW-1:0] TT_GWD   = TTW'(2);
  localparam logic [AW-1:0]  SLOT_M   = {{(AW-14){1'b0}}, {14{1'b1}}};
  localparam logic [AW-1:0]  HBASE_M  = ~SLOT_M;
  localparam logic [AW-1:0]  PBASE_M  = {{(AW-15){1'b1}}, {15{1'b0}}};
  localparam logic [AW-1:0]  NEST_BIT = AW'(1) << 14;
  localparam logic [AW-1:0]  INSN     = AW'(4);

  function automatic logic [AW-1:0] slot(input logic [TTW-1:0] t);
    return (AW'(t) << 5) & SLOT_M;
  endfunction

  logic           red_hit, err_hit, gwd_hit, hyp_hit;
  logic [1:0]     lvl_n;
  logic [4:0]     mode_n;
  logic [TTW-1:0] tt_n;
  logic [AW-1:0]  pc_n, npc_n, nnpc_n;

  assign lvl_n   = hpstate_hpriv_i ? 2'd2 : (pstate_priv_i ? 2'd1 : 2'd0);
  assign red_hit = hpstate_red_i || (tl_i == TL_RED);
  assign err_hit = tl_i >= TL_ERR;
  assign gwd_hit = (tl_i > TL_PMAX) && (tgt_lvl_i == 2'd1);
  assign hyp_hit = tgt_lvl_i == 2'd2;

  always_comb begin
    tt_n = tt_i;
    if (red_hit) begin
      mode_n = 5'b00001;
      tt_n   = TT_RED;
      pc_n   = RED_BASE | ((AW'(TT_RED) << 5) & AW'(8'hFF));
    end else if (err_hit) begin
      mode_n = 5'b00010;
      pc_n   = '0;
    end else if (gwd_hit) begin
      mode_n = 5'b00100;
      tt_n   = TT_GWD;
      pc_n   = (htba_i & HBASE_M) | slot(TT_GWD);
    end else if (hyp_hit) begin
      mode_n = 5'b01000;
      pc_n   = (htba_i & HBASE_M) | slot(tt_i);
    end else begin
      mode_n = 5'b10000;
      pc_n   = (tba_i & PBASE_M) | ((tl_i != '0) ? NEST_BIT : '0) | slot(tt_i);
    end
  end

  assign npc_n  = mode_n[1] ? '0 : pc_n + INSN;
  assign nnpc_n = mode_n[1] ? '0 : pc_n + (INSN << 1);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cur_lvl_o <= '0;
          mode_o    <= '0;
          eff_tt_o  <= '0;
          pc_o      <= '0;
          npc_o     <= '0;
          nnpc_o    <= '0;
        end else begin
          cur_lvl_o <= lvl_n;
          mode_o    <= mode_n;
          eff_tt_o  <= tt_n;
          pc_o      <= pc_n;
          npc_o     <= npc_n;
          nnpc_o    <= nnpc_n;
        end
      end
    end else begin : g_comb
      assign cur_lvl_o = lvl_n;
      assign mode_o    = mode_n;
      assign eff_tt_o  = tt_n;
      assign pc_o      = pc_n;
      assign npc_o     = npc_n;
      assign nnpc_o    = nnpc_n;
    end
  endgenerate
endmodule

module trap_vector_gen_chk #(
  parameter int AW  = 64,
  parameter int TTW = 9
) (
  input logic           clk,
  input logic           rst_n,
  input logic [4:0]     mode_o,
  input logic [TTW-1:0] eff_tt_o,
  input logic [AW-1:0]  pc_o,
  input logic [AW-1:0]  npc_o,
  input logic [AW-1:0]  nnpc_o
);
  assert_onehot_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $onehot(mode_o));
  assert_seq_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !mode_o[1]) |-> (npc_o == pc_o + AW'(4) && nnpc_o == npc_o + AW'(4)));
  assert_red_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o[0] |-> (pc_o == AW'(40'hFF_F000_00A0) && eff_tt_o == TTW'(5)));
  assert_error_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o[1] |-> (pc_o == '0 && npc_o == '0 && nnpc_o == '0));
  assert_gwd_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o[2] |-> (eff_tt_o == TTW'(2) && pc_o[13:0] == 14'h0040));
  assert_table_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o[3] || mode_o[4]) |-> (pc_o[4:0] == 5'd0));
endmodule

bind trap_vector_gen trap_vector_gen_chk #(.AW(AW), .TTW(TTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .eff_tt_o(eff_tt_o),
  .pc_o(pc_o), .npc_o(npc_o), .nnpc_o(nnpc_o)
);

// File: tb/tb_trap_vector_gen.sv
module tb_trap_vector_gen;
  localparam int MAX_TL = 6;
  localparam int MAX_PTL = 2;
  localparam logic [63:0] TBA  = 64'h0000_1234_5678_FFFF;
  localparam logic [63:0] HTBA = 64'h00AB_CDEF_0000_7FFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] tl = '0;
  logic pr = 1'b0, hp = 1'b0, red = 1'b0;
  logic [1:0] tgt = '0;
  logic [8:0] tt = '0;
  logic [1:0] cur_lvl;
  logic [4:0] mode;
  logic [8:0] eff_tt;
  logic [63:0] pc, npc, nnpc;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trap_vector_gen #(.MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL)) dut (
    .clk(clk), .rst_n(rst_n), .tl_i(tl), .pstate_priv_i(pr),
    .hpstate_hpriv_i(hp), .hpstate_red_i(red), .tgt_lvl_i(tgt), .tt_i(tt),
    .tba_i(TBA), .htba_i(HTBA), .cur_lvl_o(cur_lvl), .mode_o(mode),
    .eff_tt_o(eff_tt), .pc_o(pc), .npc_o(npc), .nnpc_o(nnpc));

  // fields: [21] red [20] hpriv [19] priv [18:17] target [16:14] tl [13:5] type [4:0] expected mode
  localparam logic [21:0] VEC [12] = '{
    {1'b1, 1'b0, 1'b0, 2'd2, 3'd0, 9'h041, 5'b00001},
    {1'b0, 1'b0, 1'b1, 2'd1, 3'd5, 9'h024, 5'b00001},
    {1'b0, 1'b1, 1'b0, 2'd1, 3'd6, 9'h030, 5'b00010},
    {1'b0, 1'b0, 1'b0, 2'd2, 3'd7, 9'h1FF, 5'b00010},
    {1'b0, 1'b0, 1'b1, 2'd1, 3'd3, 9'h068, 5'b00100},
    {1'b0, 1'b0, 1'b1, 2'd2, 3'd3, 9'h064, 5'b01000},
    {1'b0, 1'b0, 1'b1, 2'd1, 3'd2, 9'h080, 5'b10000},
    {1'b0, 1'b0, 1'b0, 2'd1, 3'd0, 9'h1FF, 5'b10000},
    {1'b0, 1'b0, 1'b0, 2'd0, 3'd1, 9'h010, 5'b10000},
    {1'b0, 1'b1, 1'b1, 2'd2, 3'd0, 9'h1FF, 5'b01000},
    {1'b0, 1'b1, 1'b0, 2'd1, 3'd4, 9'h011, 5'b00100},
    {1'b0, 1'b0, 1'b1, 2'd2, 3'd2, 9'h100, 5'b01000}
  };

  task automatic ck(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(output logic [4:0] m, output logic [8:0] t, output logic [63:0] p);
    t = tt;
    if (red || tl == 3'(MAX_TL - 1)) begin m = 5'b00001; t = 9'd5; p = 64'hFF_F000_00A0; end
    else if (tl >= 3'(MAX_TL)) begin m = 5'b00010; p = '0; end
    else if (tl > 3'(MAX_PTL) && tgt == 2'd1) begin
      m = 5'b00100; t = 9'd2; p = {HTBA[63:14], 14'h0040};
    end else if (tgt == 2'd2) begin
      m = 5'b01000; p = {HTBA[63:14], tt, 5'd0};
    end else begin
      m = 5'b10000; p = {TBA[63:15], (tl != 3'd0), tt, 5'd0};
    end
  endtask

  task automatic check_all(input string tag);
    logic [4:0] m; logic [8:0] t; logic [63:0] p;
    model(m, t, p);
    ck({tag, " R8 mode"}, 64'(mode), 64'(m));
    ck({tag, " type"}, 64'(eff_tt), 64'(t));
    ck({tag, " pc"}, pc, p);
    ck({tag, " R7 npc"}, npc, m[1] ? 64'd0 : p + 64'd4);
    ck({tag, " R7 nnpc"}, nnpc, m[1] ? 64'd0 : p + 64'd8);
    ck({tag, " R1 level"}, 64'(cur_lvl), hp ? 64'd2 : (pr ? 64'd1 : 64'd0));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    ck("R9 reset mode", 64'(mode), 64'd0);
    ck("R9 reset pc", pc, 64'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      {red, hp, pr, tgt, tl, tt} = VEC[i][21:5];
      @(negedge clk);
      ck("R2 R3 R4 R5 R6 table mode", 64'(mode), 64'(VEC[i][4:0]));
      check_all("table");
    end
    for (int i = 0; i < 400; i++) begin
      {red, hp, pr} = 3'($urandom_range(0, 7));
      if (($urandom & 3) != 0) red = 1'b0;
      tgt = 2'($urandom);
      tl = 3'($urandom);
      tt = 9'($urandom);
      @(negedge clk);
      check_all("random");
    end
    // R9: one-cycle latency, previous result held until the edge
    {red, hp, pr, tgt, tl, tt} = {1'b0, 1'b0, 1'b0, 2'd2, 3'd0, 9'h00F};
    @(negedge clk);
    tl = 3'd6;
    #1;
    ck("R9 held before edge", 64'(mode), 64'b01000);
    @(negedge clk);
    ck("R3 after edge", 64'(mode), 64'b00010);
    // R6 nesting boundary tl 0 vs 1
    tgt = 2'd1; tt = 9'h001; tl = 3'd1;
    @(negedge clk);
    ck("R6 nested half", pc, {TBA[63:15], 1'b1, 9'h001, 5'd0});
    // R4 boundary: tl equal to MAX_PTL stays privileged
    tl = 3'(MAX_PTL);
    @(negedge clk);
    ck("R4 at limit", 64'(mode), 64'b10000);
    rst_n = 1'b0;
    @(negedge clk);
    ck("R9 reset clears", nnpc, 64'd0);
    finish_run();
  end
endmodule